// File: doc/BRIEF.md
# Clock-Control Serial Register Slave

This block is a two-wire serial slave that holds the control settings of a clock synthesizer. It watches the SCL and SDA lines through a synchronizer running on a faster system clock and recognises START, repeated START and STOP. It responds to one 7-bit slave address, which is a parameter. It supports four transaction types: byte write, byte read, block write and block read. Every transaction selects its target through an 8-bit command code.

The register bank has four bytes by default. Byte 0 drives two outputs. Bit 0 switches spread-spectrum modulation on or off. Bit 1 chooses the down-spread depth: 0 selects -0.35 % and 1 selects -0.5 %. Every bit of every byte reads back as written. The slave pulls SDA low through an open-drain enable and never stretches SCL.

Top module: `clkctl_smb_slave`

## Requirements
- R1: After reset `sda_oe`, `spread_en` and `spread_depth` are all 0.
- R2: The slave acknowledges an address byte only when its upper seven bits equal `SLAVE_ADDR`. On a mismatch `sda_oe` stays 0 for the rest of the transfer, no register changes, and the bus is ignored until the next START.
- R3: In a byte write, command bit 7 is 0 and command bits 6:0 give the register offset. The slave acknowledges the address, the command and the data byte. The data byte is stored at that offset. `spread_en` follows bit 0 of register 0, and `spread_depth` follows bit 1 of register 0 (0 = -0.35 %, 1 = -0.5 %).
- R4: In a byte read, the master sends the address with the write bit, then a command with bit 7 at 0, then a repeated START and the address with the read bit. The slave then returns, MSB first, the register at the command offset.
- R5: In a block write, command bit 7 is 1. The first byte after the command is the byte count: it is acknowledged and not stored. Each following data byte goes to the next offset, counting up from the command offset. Data bytes that fall beyond the last register are acknowledged and discarded.
- R6: In a block read, command bit 7 is 1. The slave first returns the byte count, which equals the number of registers minus the offset (0 when the offset is past the end). It then returns the registers from the offset upward. Positions past the end read as 0x00.
- R7: When the master answers a read byte with NOT-ACK, the slave releases SDA and leaves it released until the next START.
- R8: A START or STOP in the middle of a byte aborts the transfer. The partial byte is not stored, and a START that follows begins a new address phase.
- R9: All eight bits of every register are readable and writable.
- R10: The slave changes `sda_oe` only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | When 1, the slave pulls SDA low |
| spread_en | output | 1 | Spread-spectrum modulation enable (register 0 bit 0) |
| spread_depth | output | 1 | Down-spread depth select, 0 = -0.35 %, 1 = -0.5 % (register 0 bit 1) |

## Verification
The assertions check on every cycle that the SDA enable moves only while SCL is low and that a START or STOP always returns the slave to a clean state with SDA released. They also check that an address mismatch and a NOT-ACK leave SDA released, that an in-range write lands in its register, and that an out-of-range write leaves the bank untouched. Only the bench's scenarios can show that whole transactions work end to end. These cover the byte count returned for each offset, register contents across back-to-back block writes that run off the end of the bank, readback of data through repeated START, and register contents surviving an aborted transfer.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  localparam int BYTE_W        = 8;
  localparam int PTR_W         = 7;
  localparam int CMD_BLOCK_BIT = 7;
  localparam int SS_EN_BIT     = 0;
  localparam int SS_DEPTH_BIT  = 1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_CMD_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_TX_ACK
  } smb_state_e;

endpackage

// File: rtl/clkctl_line_sync.sv
module clkctl_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe_q, scl_pipe_d;
  logic [STAGES-1:0] sda_pipe_q, sda_pipe_d;
  logic              scl_prev_q, sda_prev_q;

  always_comb begin
    scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_i};
    sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_i};
  end

  // Idle bus level is high on both lines.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_pipe_q <= scl_pipe_d;
      sda_pipe_q <= sda_pipe_d;
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_s     = scl_pipe_q[STAGES-1];
  assign sda_s     = sda_pipe_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev_q;
  assign scl_fall  = ~scl_s & scl_prev_q;
  assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank
  import clkctl_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              spread_en,
  output logic              spread_depth
);

  localparam logic [PTR_W:0] NREG_EXT = (PTR_W+1)'(NUM_REGS);
  localparam int             FLAT_W   = NUM_REGS * BYTE_W;

  logic [BYTE_W-1:0] regs_q [NUM_REGS];
  logic [NUM_REGS-1:0] wr_hit;
  logic [FLAT_W-1:0]   regs_flat;
  logic                wr_in_range;

  assign wr_in_range = {1'b0, wr_ptr} < NREG_EXT;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign wr_hit[i] = wr_en && wr_in_range && (wr_ptr == PTR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[i] <= '0;
      end else if (wr_hit[i]) begin
        regs_q[i] <= wr_data;
      end
    end

    assign regs_flat[i*BYTE_W +: BYTE_W] = regs_q[i];

    // R3 / R9: an in-range write is stored in full in its register
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[i] |=> regs_q[i] == $past(wr_data));
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_ptr == PTR_W'(i)) rd_data = regs_q[i];
    end
  end

  assign spread_en    = regs_q[0][SS_EN_BIT];
  assign spread_depth = regs_q[0][SS_DEPTH_BIT];

  // R5: a write past the end of the bank changes nothing
  assert_oob_discard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_in_range) |=> $stable(regs_flat));

endmodule

// File: rtl/clkctl_smb_fsm.sv
module clkctl_smb_fsm
  import clkctl_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h6A,
  parameter int         NUM_REGS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [PTR_W-1:0]  rd_ptr,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_ptr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_oe
);

  localparam logic [BYTE_W-1:0] NREG_B   = BYTE_W'(NUM_REGS);
  localparam logic [3:0]        BITS_END = 4'd8;

  smb_state_e        state_q, state_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              blk_q, blk_d;
  logic              rw_q, rw_d;
  logic              nack_q, nack_d;
  logic              oe_q, oe_d;

  logic [PTR_W-1:0]  ptr_inc;
  logic [BYTE_W-1:0] count_byte;
  logic [BYTE_W-1:0] nxt_byte;
  logic [BYTE_W-1:0] sh_in;
  logic              byte_done;

  assign ptr_inc    = (ptr_q == '1) ? ptr_q : ptr_q + 1'b1;
  assign count_byte = ({1'b0, ptr_q} < NREG_B) ? (NREG_B - {1'b0, ptr_q}) : '0;
  assign nxt_byte   = blk_q ? count_byte : rd_data;
  assign sh_in      = {sh_q[BYTE_W-2:0], sda_s};
  assign byte_done  = scl_fall && (cnt_q == BITS_END);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    blk_d   = blk_q;
    rw_d    = rw_q;
    nack_d  = nack_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;

    unique case (state_q)
      ST_IDLE: ;
      ST_ADDR, ST_CMD, ST_WDATA: begin
        if (scl_rise) begin
          sh_d  = sh_in;
          cnt_d = cnt_q + 4'd1;
        end else if (byte_done) begin
          if (state_q == ST_ADDR) begin
            if (sh_q[7:1] == SLAVE_ADDR) begin
              rw_d    = sh_q[0];
              state_d = ST_ADDR_ACK;
              oe_d    = 1'b1;
            end else begin
              state_d = ST_IDLE;
            end
          end else if (state_q == ST_CMD) begin
            ptr_d   = sh_q[PTR_W-1:0];
            blk_d   = sh_q[CMD_BLOCK_BIT];
            state_d = ST_CMD_ACK;
            oe_d    = 1'b1;
          end else begin
            if (blk_q) begin
              blk_d = 1'b0;
            end else begin
              wr_en = 1'b1;
              ptr_d = ptr_inc;
            end
            state_d = ST_WDATA_ACK;
            oe_d    = 1'b1;
          end
        end
      end
      ST_ADDR_ACK, ST_TX_ACK: begin
        if (scl_rise && state_q == ST_TX_ACK) begin
          nack_d = sda_s;
        end else if (scl_fall) begin
          cnt_d = '0;
          if (state_q == ST_TX_ACK && nack_q) begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
          end else if (state_q == ST_ADDR_ACK && !rw_q) begin
            state_d = ST_CMD;
            oe_d    = 1'b0;
          end else begin
            state_d = ST_TX;
            tx_d    = nxt_byte;
            oe_d    = ~nxt_byte[BYTE_W-1];
            if (blk_q) blk_d = 1'b0;
            else       ptr_d = ptr_inc;
          end
        end
      end
      ST_CMD_ACK, ST_WDATA_ACK: begin
        if (scl_fall) begin
          state_d = ST_WDATA;
          cnt_d   = '0;
          oe_d    = 1'b0;
        end
      end
      ST_TX: begin
        if (scl_rise) begin
          cnt_d = cnt_q + 4'd1;
        end else if (byte_done) begin
          state_d = ST_TX_ACK;
          oe_d    = 1'b0;
        end else if (scl_fall) begin
          tx_d = {tx_q[BYTE_W-2:0], 1'b0};
          oe_d = ~tx_q[BYTE_W-2];
        end
      end
      default: begin
        state_d = ST_IDLE;
        oe_d    = 1'b0;
      end
    endcase

    // Bus conditions override whatever the byte machine was doing.
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
      wr_en   = 1'b0;
    end
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
      wr_en   = 1'b0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      blk_q   <= 1'b0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      blk_q   <= blk_d;
      rw_q    <= rw_d;
      nack_q  <= nack_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe  = oe_q;
  assign rd_ptr  = ptr_q;
  assign wr_ptr  = ptr_q;
  assign wr_data = sh_q;

  // R10: SDA drive changes only while SCL is low
  assert_sda_moves_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s);

  // R8: a START restarts address collection with SDA released
  assert_start_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state_q == ST_ADDR) && !oe_q && (cnt_q == 4'd0));

  // R8: a STOP returns the slave to idle with SDA released
  assert_stop_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (state_q == ST_IDLE) && !oe_q);

  // R2: a foreign address leaves SDA released
  assert_no_ack_foreign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ADDR && byte_done && sh_q[7:1] != SLAVE_ADDR && !start_det)
      |=> !oe_q && state_q == ST_IDLE);

  // R7: a NOT-ACK from the master ends the read with SDA released
  assert_nack_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TX_ACK && scl_fall && nack_q && !start_det) |=> !oe_q && state_q == ST_IDLE);

endmodule

// File: rtl/clkctl_smb_slave.sv
module clkctl_smb_slave
  import clkctl_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h6A,
  parameter int         NUM_REGS    = 4,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic spread_en,
  output logic spread_depth
);

  logic [1:0]        rst_pipe_q;
  logic              rst_s_n;
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [BYTE_W-1:0] wr_data, rd_data;

  // Reset asserts at once and releases two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  clkctl_line_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  clkctl_smb_fsm #(
    .SLAVE_ADDR (SLAVE_ADDR),
    .NUM_REGS   (NUM_REGS)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .rd_ptr    (rd_ptr),
    .wr_en     (wr_en),
    .wr_ptr    (wr_ptr),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe)
  );

  clkctl_regbank #(
    .NUM_REGS (NUM_REGS)
  ) u_bank (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .wr_en        (wr_en),
    .wr_ptr       (wr_ptr),
    .wr_data      (wr_data),
    .rd_ptr       (rd_ptr),
    .rd_data      (rd_data),
    .spread_en    (spread_en),
    .spread_depth (spread_depth)
  );

endmodule

// File: tb/sim_clkctl_smb_slave.sv
module sim_clkctl_smb_slave;

  localparam int         CLK_PERIOD = 10;
  localparam int         Q          = 8;
  localparam logic [6:0] ADDR       = 7'h6A;

  typedef logic [7:0] byte_q_t [$];
  typedef struct { logic [7:0] val; string req; } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_drv, sda_drv;
  logic sda_line;
  logic sda_oe, spread_en, spread_depth;

  int n_checks = 0;
  int n_fail   = 0;

  exp_t       exp_q [$];
  logic [7:0] act_q [$];

  logic watch_oe = 1'b0;
  logic oe_seen  = 1'b0;
  int   oe_viol  = 0;
  logic oe_prev  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_drv & ~sda_oe;

  clkctl_smb_slave #(
    .SLAVE_ADDR  (ADDR),
    .NUM_REGS    (4),
    .SYNC_STAGES (2)
  ) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_i        (scl_drv),
    .sda_i        (sda_line),
    .sda_oe       (sda_oe),
    .spread_en    (spread_en),
    .spread_depth (spread_depth)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compares every byte read from the bus with the scoreboard.
  always @(negedge clk) begin
    if (watch_oe && sda_oe) oe_seen <= 1'b1;
    if (sda_oe != oe_prev && scl_drv) oe_viol <= oe_viol + 1;
    oe_prev <= sda_oe;
    while (act_q.size() > 0) begin
      logic [7:0] got;
      got = act_q.pop_front();
      if (exp_q.size() == 0) begin
        check(1'b0, "SCOREBOARD", {24'h0, got}, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(got == e.val, e.req, {24'h0, got}, {24'h0, e.val});
      end
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start();
    sda_drv = 1'b1; scl_drv = 1'b1; hold(Q);
    sda_drv = 1'b0; hold(Q);
    scl_drv = 1'b0; hold(Q);
  endtask

  task automatic m_rstart();
    sda_drv = 1'b1; hold(Q);
    scl_drv = 1'b1; hold(Q);
    sda_drv = 1'b0; hold(Q);
    scl_drv = 1'b0; hold(Q);
  endtask

  task automatic m_stop();
    sda_drv = 1'b0; hold(Q);
    scl_drv = 1'b1; hold(Q);
    sda_drv = 1'b1; hold(2*Q);
  endtask

  task automatic m_bit_out(input logic b);
    sda_drv = b; hold(Q);
    scl_drv = 1'b1; hold(2*Q);
    scl_drv = 1'b0; hold(Q);
  endtask

  task automatic m_bit_in(output logic b);
    sda_drv = 1'b1; hold(Q);
    scl_drv = 1'b1; hold(Q);
    b = sda_line; hold(Q);
    scl_drv = 1'b0; hold(Q);
  endtask

  task automatic m_send(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) m_bit_out(d[i]);
    m_bit_in(ack);
  endtask

  task automatic m_recv(input logic nack);
    logic [7:0] d;
    logic       b;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      m_bit_in(b);
      d = {d[6:0], b};
    end
    m_bit_out(nack);
    act_q.push_back(d);
  endtask

  task automatic expect_byte(input logic [7:0] v, input string req);
    exp_t e;
    e.val = v; e.req = req;
    exp_q.push_back(e);
  endtask

  // Driver: a write transfer with every acknowledge checked.
  task automatic do_write(input logic [7:0] cmd, input byte_q_t data, input string req);
    logic ack;
    m_start();
    m_send({ADDR, 1'b0}, ack); check(ack == 1'b0, req, {31'h0, ack}, 32'h0);
    m_send(cmd, ack);          check(ack == 1'b0, req, {31'h0, ack}, 32'h0);
    foreach (data[i]) begin
      m_send(data[i], ack);    check(ack == 1'b0, req, {31'h0, ack}, 32'h0);
    end
    m_stop();
  endtask

  // Driver: a read transfer; expected bytes go to the scoreboard first.
  task automatic do_read(input logic [7:0] cmd, input byte_q_t exp, input string req);
    logic ack;
    foreach (exp[i]) expect_byte(exp[i], req);
    m_start();
    m_send({ADDR, 1'b0}, ack); check(ack == 1'b0, req, {31'h0, ack}, 32'h0);
    m_send(cmd, ack);          check(ack == 1'b0, req, {31'h0, ack}, 32'h0);
    m_rstart();
    m_send({ADDR, 1'b1}, ack); check(ack == 1'b0, req, {31'h0, ack}, 32'h0);
    for (int i = 0; i < exp.size(); i++) m_recv(i == exp.size() - 1);
    m_stop();
  endtask

  task automatic finish_run();
    hold(4);
    check(exp_q.size() == 0, "SCOREBOARD", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL WATCHDOG: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    logic b;
    logic [7:0] tail;
    rst_n = 1'b0; scl_drv = 1'b1; sda_drv = 1'b1;
    hold(5);
    rst_n = 1'b1;
    hold(6);

    // R1: reset state
    check(sda_oe == 1'b0,       "R1", {31'h0, sda_oe}, 32'h0);
    check(spread_en == 1'b0,    "R1", {31'h0, spread_en}, 32'h0);
    check(spread_depth == 1'b0, "R1", {31'h0, spread_depth}, 32'h0);

    // R3: byte write to register 0 drives both controls
    do_write(8'h00, '{8'h03}, "R3");
    check(spread_en == 1'b1,    "R3", {31'h0, spread_en}, 32'h1);
    check(spread_depth == 1'b1, "R3", {31'h0, spread_depth}, 32'h1);
    do_write(8'h00, '{8'h01}, "R3");
    check(spread_en == 1'b1,    "R3", {31'h0, spread_en}, 32'h1);
    check(spread_depth == 1'b0, "R3", {31'h0, spread_depth}, 32'h0);

    // R4: byte read through repeated START
    do_read(8'h00, '{8'h01}, "R4");

    // R5 / R9: block write from offset 1, full-byte patterns
    do_write(8'h81, '{8'h03, 8'hA5, 8'h5A, 8'hC3}, "R5");
    // R6 / R9: block read returns count then bytes
    do_read(8'h81, '{8'h03, 8'hA5, 8'h5A, 8'hC3}, "R6");

    // R5: block write running past the end, extra bytes discarded
    do_write(8'h82, '{8'h04, 8'h11, 8'h22, 8'h33, 8'h44}, "R5");
    check(spread_en == 1'b1, "R5", {31'h0, spread_en}, 32'h1);
    do_read(8'h80, '{8'h04, 8'h01, 8'hA5, 8'h11, 8'h22}, "R6");

    // R9: byte write and read of the last register
    do_write(8'h03, '{8'hFE}, "R9");
    do_read(8'h03, '{8'hFE}, "R9");

    // R6: offset past the end gives count 0 and zero data
    do_read(8'h86, '{8'h00, 8'h00}, "R6");

    // R2: foreign address is not acknowledged and changes nothing
    watch_oe = 1'b1; oe_seen = 1'b0;
    m_start();
    m_send({7'h12, 1'b0}, ack); check(ack == 1'b1, "R2", {31'h0, ack}, 32'h1);
    m_send(8'h00, ack);         check(ack == 1'b1, "R2", {31'h0, ack}, 32'h1);
    m_send(8'h00, ack);         check(ack == 1'b1, "R2", {31'h0, ack}, 32'h1);
    m_stop();
    hold(2);
    watch_oe = 1'b0;
    check(oe_seen == 1'b0,   "R2", {31'h0, oe_seen}, 32'h0);
    check(spread_en == 1'b1, "R2", {31'h0, spread_en}, 32'h1);

    // R8: START mid data byte, then STOP mid data byte
    m_start();
    m_send({ADDR, 1'b0}, ack); check(ack == 1'b0, "R8", {31'h0, ack}, 32'h0);
    m_send(8'h00, ack);        check(ack == 1'b0, "R8", {31'h0, ack}, 32'h0);
    for (int i = 0; i < 4; i++) m_bit_out(1'b0);
    m_rstart();
    m_stop();
    m_start();
    m_send({ADDR, 1'b0}, ack); check(ack == 1'b0, "R8", {31'h0, ack}, 32'h0);
    m_send(8'h00, ack);        check(ack == 1'b0, "R8", {31'h0, ack}, 32'h0);
    for (int i = 0; i < 3; i++) m_bit_out(1'b0);
    m_stop();
    check(spread_en == 1'b1, "R8", {31'h0, spread_en}, 32'h1);
    do_read(8'h00, '{8'h01}, "R8");

    // R7: after NOT-ACK the slave stays off SDA
    expect_byte(8'h04, "R7");
    m_start();
    m_send({ADDR, 1'b0}, ack); check(ack == 1'b0, "R7", {31'h0, ack}, 32'h0);
    m_send(8'h80, ack);        check(ack == 1'b0, "R7", {31'h0, ack}, 32'h0);
    m_rstart();
    m_send({ADDR, 1'b1}, ack); check(ack == 1'b0, "R7", {31'h0, ack}, 32'h0);
    m_recv(1'b1);
    watch_oe = 1'b1; oe_seen = 1'b0;
    tail = '0;
    for (int i = 0; i < 8; i++) begin
      m_bit_in(b);
      tail = {tail[6:0], b};
    end
    watch_oe = 1'b0;
    check(tail == 8'hFF,   "R7", {24'h0, tail}, 32'hFF);
    check(oe_seen == 1'b0, "R7", {31'h0, oe_seen}, 32'h0);
    m_stop();

    // R10: SDA enable never moved while SCL was high
    check(oe_viol == 0, "R10", oe_viol, 0);

    finish_run();
  end

endmodule